// File: doc/BRIEF.md
# Accumulating Calculator with Single-Level Undo

This block is a tiny special-purpose processor that keeps a running 8-bit result and updates it on command. A controller state machine sequences a datapath holding three registers: an operand register that captures the input word, a result register that is driven to the output, and a history register that keeps the result as it stood before the most recent change. A user gives a command by pulsing exactly one of three command inputs (add, multiply, undo) for a single clock cycle.

Add and multiply take two cycles. In the first, the controller is idle and captures the input word into the operand register. In the second, it writes the sum or the truncated product into the result register and moves the old result into history. Undo exchanges the result and history registers in one step, so a second undo brings back the value that the first undo removed. The input word is not used by undo.

Controller states and transitions: `ST_RESET` clears every register and always moves to `ST_WAIT`. `ST_WAIT` stays put with no command, moves to `ST_ADD` on add, to `ST_MUL` on multiply and to `ST_UNDO` on undo (if several pulses coincide, add wins over multiply, and multiply over undo). `ST_ADD`, `ST_MUL` and `ST_UNDO` each perform their register update and return to `ST_WAIT` unconditionally. An asynchronous active-low reset forces `ST_RESET`.

Top module: `accum_calc`

## Requirements
- R1: While reset is low and in the first cycle after it rises, the result is 0; a command pulse given in that first cycle (the clearing state) is ignored.
- R2: An add pulse sampled in the idle state loads the input word as operand; one clock edge later the result becomes (old result + operand) modulo 256, visible after the second edge counted from the pulse.
- R3: A multiply pulse behaves like add, but the new result is the low 8 bits of old result times operand.
- R4: Each add or multiply copies the result it replaces into history, so an undo that follows restores that earlier result after two edges.
- R5: Undo exchanges result and history in one step; two undos in a row leave the result as it was before them.
- R6: Undo does not use or capture the input word: the outcome of an undo and of any later operation is independent of the word present with the undo pulse.
- R7: A command pulse that arrives while an operation state is active (the cycle after a command is accepted) is ignored entirely.
- R8: With no command asserted in the idle state, the result and history stay unchanged.
- R9: An undo issued before any add or multiply after reset gives a result of 0, since history is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_add | input | 1 | One-cycle pulse: add input word to result |
| cmd_mul | input | 1 | One-cycle pulse: multiply result by input word |
| cmd_undo | input | 1 | One-cycle pulse: swap result and history |
| din | input | 8 | Operand word, sampled with an add or multiply pulse |
| result | output | 8 | Current content of the result register |

## Verification
The two functions that share a cycle are the register update of an operation state and the arrival of a fresh command pulse, which the controller must drop because it is not idle. The bench provokes this by issuing commands on consecutive cycles, both in directed sequences (an add directly followed by a multiply, an undo directly followed by an add) and in a random stream where every cycle has a good chance of carrying a pulse. Each cycle is judged by comparing the result port against a bench model in which pulses outside the idle state have no effect, so a design that accepted the second pulse would diverge from the model within two cycles.

// File: rtl/accum_calc_pkg.sv
package accum_calc_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_WAIT  = 3'd1,
        ST_ADD   = 3'd2,
        ST_MUL   = 3'd3,
        ST_UNDO  = 3'd4
    } calc_state_e;

    typedef struct packed {
        logic clr;        // synchronous clear of all registers
        logic en_opnd;    // load operand register from din
        logic en_res;     // load result register
        logic en_hist;    // load history register from result
        logic alu_mul;    // 0: add, 1: multiply
        logic pick_hist;  // 0: result <- alu, 1: result <- history
    } calc_ctrl_t;

endpackage

// File: rtl/calc_alu.sv
module calc_alu #(
    parameter int W = 8
) (
    input  logic         sel_mul,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] y
);
    logic [W-1:0] sum_w;
    logic [W-1:0] prod_w;

    assign sum_w  = op_a + op_b;
    assign prod_w = op_a * op_b;   // low W bits of the product
    assign y      = sel_mul ? prod_w : sum_w;
endmodule

// File: rtl/calc_reg.sv
module calc_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/calc_ctrl.sv
module calc_ctrl
    import accum_calc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_add,
    input  logic        cmd_mul,
    input  logic        cmd_undo,
    output calc_state_e state_o,
    output calc_ctrl_t  ctrl_o
);
    calc_state_e state_q;
    calc_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_WAIT;
            ST_WAIT: begin
                if (cmd_add)
                    state_d = ST_ADD;
                else if (cmd_mul)
                    state_d = ST_MUL;
                else if (cmd_undo)
                    state_d = ST_UNDO;
            end
            ST_ADD:   state_d = ST_WAIT;
            ST_MUL:   state_d = ST_WAIT;
            ST_UNDO:  state_d = ST_WAIT;
            default:  state_d = ST_RESET;
        endcase
    end

    // outputs
    always_comb begin
        ctrl_o = '0;
        unique case (state_q)
            ST_RESET: ctrl_o.clr = 1'b1;
            ST_WAIT:  ctrl_o.en_opnd = cmd_add | cmd_mul;
            ST_ADD: begin
                ctrl_o.en_res  = 1'b1;
                ctrl_o.en_hist = 1'b1;
            end
            ST_MUL: begin
                ctrl_o.en_res  = 1'b1;
                ctrl_o.en_hist = 1'b1;
                ctrl_o.alu_mul = 1'b1;
            end
            ST_UNDO: begin
                ctrl_o.en_res    = 1'b1;
                ctrl_o.en_hist   = 1'b1;
                ctrl_o.pick_hist = 1'b1;
            end
            default: ctrl_o.clr = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
    import accum_calc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  calc_ctrl_t   ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] opnd_q,
    output logic [W-1:0] res_q,
    output logic [W-1:0] hist_q
);
    logic [W-1:0] alu_y;
    logic [W-1:0] res_d;

    calc_reg #(.W(W)) u_opnd (
        .clk(clk), .rst_n(rst_n), .clr(ctrl.clr), .en(ctrl.en_opnd),
        .d(din), .q(opnd_q)
    );

    calc_alu #(.W(W)) u_alu (
        .sel_mul(ctrl.alu_mul), .op_a(res_q), .op_b(opnd_q), .y(alu_y)
    );

    assign res_d = ctrl.pick_hist ? hist_q : alu_y;

    calc_reg #(.W(W)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(ctrl.clr), .en(ctrl.en_res),
        .d(res_d), .q(res_q)
    );

    calc_reg #(.W(W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(ctrl.clr), .en(ctrl.en_hist),
        .d(res_q), .q(hist_q)
    );
endmodule

// File: rtl/accum_calc.sv
module accum_calc
    import accum_calc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_add,
    input  logic         cmd_mul,
    input  logic         cmd_undo,
    input  logic [W-1:0] din,
    output logic [W-1:0] result
);
    calc_state_e  fsm_state;
    calc_ctrl_t   ctrl;
    logic [W-1:0] opnd_q;
    logic [W-1:0] res_q;
    logic [W-1:0] hist_q;

    calc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_add(cmd_add), .cmd_mul(cmd_mul), .cmd_undo(cmd_undo),
        .state_o(fsm_state), .ctrl_o(ctrl)
    );

    calc_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .din(din),
        .opnd_q(opnd_q), .res_q(res_q), .hist_q(hist_q)
    );

    assign result = res_q;
endmodule

// File: rtl/accum_calc_chk.sv
module accum_calc_chk
    import accum_calc_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_add,
    input logic         cmd_mul,
    input logic         cmd_undo,
    input logic [W-1:0] din,
    input calc_state_e  state,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] reg_r,
    input logic [W-1:0] reg_t
);
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RESET |=> (reg_a == '0 && reg_r == '0 && reg_t == '0 && state == ST_WAIT));

    a_r2_capture_add: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && cmd_add) |=> (reg_a == $past(din) && state == ST_ADD));

    a_r2_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADD |=> reg_r == W'($past(reg_r) + $past(reg_a)));

    a_r3_mul_result: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_MUL |=> reg_r == W'($past(reg_r) * $past(reg_a)));

    a_r4_history_saved: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADD || state == ST_MUL) |=> (reg_t == $past(reg_r) && state == ST_WAIT));

    a_r5_undo_swap: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_UNDO |=> (reg_r == $past(reg_t) && reg_t == $past(reg_r)));

    a_r6_undo_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && cmd_undo && !cmd_add && !cmd_mul) |=> ($stable(reg_a) && state == ST_UNDO));

    a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT && state != ST_RESET) |=> ($stable(reg_a) && state == ST_WAIT));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT |=> ($stable(reg_r) && $stable(reg_t)));
endmodule

bind accum_calc accum_calc_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_add(cmd_add), .cmd_mul(cmd_mul), .cmd_undo(cmd_undo),
    .din(din), .state(fsm_state),
    .reg_a(opnd_q), .reg_r(res_q), .reg_t(hist_q)
);

// File: tb/accum_calc_tb_top.sv
`timescale 1ns/1ps
module accum_calc_tb_top;
    localparam int W = 8;
    localparam int N_RANDOM = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_add = 1'b0;
    logic         cmd_mul = 1'b0;
    logic         cmd_undo = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // bench model: 0 clear, 1 idle, 2 add, 3 mul, 4 undo
    int           m_st = 0;
    logic [W-1:0] m_a = '0;
    logic [W-1:0] m_r = '0;
    logic [W-1:0] m_t = '0;

    always #10 clk = ~clk;   // 50 MHz

    accum_calc #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_add(cmd_add), .cmd_mul(cmd_mul), .cmd_undo(cmd_undo),
        .din(din), .result(result)
    );

    function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
        return W'(x + y);
    endfunction

    function automatic logic [W-1:0] f_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [2*W-1:0] p;
        p = x * y;
        return p[W-1:0];
    endfunction

    task automatic model_edge(input bit a, input bit m, input bit u, input logic [W-1:0] d);
        logic [W-1:0] old_r;
        old_r = m_r;
        case (m_st)
            0: begin m_a = '0; m_r = '0; m_t = '0; m_st = 1; end
            1: begin
                if (a)      begin m_a = d; m_st = 2; end
                else if (m) begin m_a = d; m_st = 3; end
                else if (u) m_st = 4;
            end
            2: begin m_r = f_add(old_r, m_a); m_t = old_r; m_st = 1; end
            3: begin m_r = f_mul(old_r, m_a); m_t = old_r; m_st = 1; end
            default: begin m_r = m_t; m_t = old_r; m_st = 1; end
        endcase
    endtask

    task automatic check(input string req, input logic [W-1:0] exp_v);
        n_checks++;
        if (result !== exp_v) begin
            n_fails++;
            $display("FAIL %s: result actual %0d expected %0d at %0t", req, result, exp_v, $time);
        end
    endtask

    // called at a falling edge; drives inputs for one cycle, checks after the edge
    task automatic step(input bit a, input bit m, input bit u, input logic [W-1:0] d, input string req);
        cmd_add = a; cmd_mul = m; cmd_undo = u; din = d;
        @(posedge clk);
        model_edge(a, m, u, d);
        @(negedge clk);
        cmd_add = 1'b0; cmd_mul = 1'b0; cmd_undo = 1'b0;
        check(req, m_r);
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0C1A;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        check("R1", 8'd0);                       // held in reset
        rst_n = 1'b1;
        // R1: first cycle is the clearing state; add pulse is ignored
        step(1, 0, 0, 8'd7, "R1");
        step(0, 0, 0, 8'd0, "R1");
        check("R1", 8'd0);
        // R9: undo straight after reset yields zero
        step(0, 0, 1, 8'd0, "R9");
        step(0, 0, 0, 8'd0, "R9");
        check("R9", 8'd0);
        // R2: add 5
        step(1, 0, 0, 8'd5, "R2");
        step(0, 0, 0, 8'd0, "R2");
        check("R2", 8'd5);
        // R3: multiply by 3
        step(0, 1, 0, 8'd3, "R3");
        step(0, 0, 0, 8'd0, "R3");
        check("R3", 8'd15);
        // R2: wrap modulo 256
        step(1, 0, 0, 8'd250, "R2");
        step(0, 0, 0, 8'd0, "R2");
        check("R2", 8'd9);
        // R3: truncated product 9*200 = 1800 -> 8
        step(0, 1, 0, 8'd200, "R3");
        step(0, 0, 0, 8'd0, "R3");
        check("R3", 8'd8);
        // R4: undo restores the pre-multiply value
        step(0, 0, 1, 8'd0, "R4");
        step(0, 0, 0, 8'd0, "R4");
        check("R4", 8'd9);
        // R5: undo of undo
        step(0, 0, 1, 8'd0, "R5");
        step(0, 0, 0, 8'd0, "R5");
        check("R5", 8'd8);
        // R6: undo with a non-zero word, then a multiply by 1 must reuse nothing of it
        step(0, 0, 1, 8'hFF, "R6");
        step(0, 0, 0, 8'd0, "R6");
        check("R6", 8'd9);
        step(0, 1, 0, 8'd1, "R6");
        step(0, 0, 0, 8'd0, "R6");
        check("R6", 8'd9);
        // R7: back-to-back pulses, second lands in an operation state
        step(1, 0, 0, 8'd1, "R7");
        step(0, 1, 0, 8'd100, "R7");
        check("R7", 8'd10);
        step(0, 0, 1, 8'd0, "R7");
        step(1, 0, 0, 8'd50, "R7");
        check("R7", 8'd9);
        step(0, 0, 0, 8'd0, "R7");
        // R8: idle cycles hold the result
        for (int i = 0; i < 5; i++) step(0, 0, 0, 8'(i * 37), "R8");
        check("R8", 8'd9);

        // constrained random stream, many pulses land in busy cycles (R7)
        for (int i = 0; i < N_RANDOM; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            case (k)
                0, 1, 2: step(1, 0, 0, 8'($urandom), "R2");
                3, 4:    step(0, 1, 0, 8'($urandom), "R3");
                5, 6:    step(0, 0, 1, 8'($urandom), "R5");
                default: step(0, 0, 0, 8'($urandom), "R8");
            endcase
        end
        summary();
    end
endmodule